// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches a gated logic domain on and off in a fixed order that keeps the domain's outputs safe while its supply comes and goes. It drives the domain's rail enable, its output clamp, one reset line per domain clock, the halt requests of up to two bus ports, and a memory-retain flag. A power-up or power-down command starts a sequence. All waits between steps are counted in cycles of the bus clock, and a frequency parameter turns microsecond delays into cycle counts.

Each bus port goes through a request/acknowledge handshake. An acknowledge that does not arrive within a timeout aborts the sequence. The abort restores the port halt requests that were in place before the sequence began and raises an error pulse. A command that asks for the state the domain is already in finishes at once with no action. A small control register keeps the all-enable delay and a retention field, and it shows the live clamp and rail bits. The all-enable output follows the rail after that programmable number of cycles.

Top module: `pd_seq`

## Requirements
- R1: After reset the domain is off: clamp_o=1, rail_en_o=0, every dom_rst_o bit 1, halt_o=2'b11, retain_o=0, en_all_o=0, busy_o=0.
- R2: ctrl_o shows the all-enable delay in bits [4:0] (reset value 31), the clamp in bit 5, the rail enable in bit 8 and the retention field in bit 9 (reset value 0). All other bits read 0. A cfg_we_i write changes only bits [4:0] and bit 9. Bits 5 and 8 follow the sequencer only.
- R3: A power-up command with rail_en_o=1 and clamp_o=0 gives done_o within two cycles and changes no output.
- R4: A power-down command with rail_en_o=0 gives done_o within two cycles and changes no output.
- R5: Power-up order: release port 0 then port 1, assert all resets, wait the reset delay, set the rail, wait exactly CLK_MHZ cycles, clear the clamp, then clear the resets one per cycle in ascending index order, then set retain_o and pulse done_o.
- R6: Power-down order: clear retain_o, halt port 0 then port 1, set the resets one per cycle in descending index order, wait the reset delay, set the clamp, clear the rail on the next cycle, then pulse done_o.
- R7: The reset delay is rst_dly_i*CLK_MHZ cycles, or CLK_MHZ cycles when rst_dly_i is 0. On power-down the clamp rises exactly that many cycles after reset line 0 rises.
- R8: With CORE_PULSE=1, reset line CORE_IDX (default 0) is pulsed once more after the forward release. It falls twice during each full power-up, and every other line falls once.
- R9: The handshake for port p completes when halted_i[p] equals halt_o[p]. A port whose port_mask_i bit is 0 is skipped, and its halt_o bit stays unchanged.
- R10: When an acknowledge is missing for TMO cycles, halt_o returns to its value from before the command, rail, clamp and resets stay as they were, err_o pulses and done_o does not. After an aborted power-down retain_o is 1.
- R11: en_all_o rises exactly D cycles after rail_en_o rises, where D is ctrl bits [4:0]. It is never 1 while rail_en_o is 0.
- R12: Commands are ignored while busy_o=1. When both commands arrive in the same idle cycle, power-up wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_up_i | input | 1 | Power-up command pulse |
| cmd_down_i | input | 1 | Power-down command pulse |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write data |
| rst_dly_i | input | 4 | Reset delay in microseconds (0 selects 1) |
| port_mask_i | input | 2 | Bus port present flags |
| halted_i | input | 2 | Bus port halt acknowledge state |
| halt_o | output | 2 | Bus port halt requests |
| rail_en_o | output | 1 | Rail enable |
| clamp_o | output | 1 | Output clamp |
| dom_rst_o | output | 4 | Domain clock resets, active high |
| retain_o | output | 1 | Memory-retain flag |
| en_all_o | output | 1 | Delayed all-enable |
| ctrl_o | output | 16 | Control register read value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished pulse |
| err_o | output | 1 | Sequence aborted pulse |

## Verification
The assertions take for granted that command inputs are low during reset, that the port acknowledges change only in answer to halt_o, and that rst_dly_i and port_mask_i stay fixed while a sequence runs. The bench models each port as a responder that copies halt_o to halted_i after a random latency well below the timeout, or that freezes to create an abort. It changes rst_dly_i, port_mask_i and the stuck flags only between commands, after the responders have settled.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PREQ, S_PWAIT, S_RST_ON, S_RST_WAIT, S_US_WAIT,
    S_RST_OFF, S_CORE_ON, S_CORE_W1, S_CORE_W2, S_RAIL_OFF
  } seq_state_e;
endpackage

// File: rtl/pd_dly.sv
module pd_dly #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R7
  expired_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/pd_enall.sv
module pd_enall #(
  parameter int DW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rail_i,
  input  logic [DW-1:0] dly_i,
  output logic          en_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!rail_i)        cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign en_o = rail_i && (cnt_q >= dly_i);
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_seq_pkg::*;
#(
  parameter int NRST       = 4,
  parameter int CLK_MHZ    = 8,
  parameter int TMO        = 16,
  parameter int RDW        = 4,
  parameter int CORE_PULSE = 1,
  parameter int CORE_IDX   = 0,
  parameter int CTRL_W     = 16,
  parameter int DLY_W      = 5,
  parameter int DLY_INIT   = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_up_i,
  input  logic              cmd_down_i,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  input  logic [RDW-1:0]    rst_dly_i,
  input  logic [1:0]        port_mask_i,
  input  logic [1:0]        halted_i,
  output logic [1:0]        halt_o,
  output logic              rail_en_o,
  output logic              clamp_o,
  output logic [NRST-1:0]   dom_rst_o,
  output logic              retain_o,
  output logic              en_all_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CLAMP_B = 5;
  localparam int RAIL_B  = 8;
  localparam int RET_B   = 9;
  localparam int US_CYC  = CLK_MHZ;
  localparam int IW      = (NRST > 1) ? $clog2(NRST) : 1;
  localparam int CW      = $clog2((1 << RDW) * US_CYC + TMO + 1) + 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NRST - 1);

  seq_state_e      state_q;
  logic            up_q, pidx_q;
  logic [IW-1:0]   ridx_q;
  logic [1:0]      halt_q, halt_sv_q;
  logic            rail_q, clamp_q, ret_flag_q, done_q, err_q;
  logic [NRST-1:0] rst_q;
  logic [DLY_W-1:0] dly_q;
  logic            cfg_ret_q;

  logic [CW-1:0]   rst_cyc;
  logic            step_ld, step_zero, tmo_ld, tmo_zero;
  logic [CW-1:0]   step_val;
  logic            tgt, ack_ok;
  logic [CTRL_W-1:0] unused_wdata;

  assign unused_wdata = cfg_wdata_i;
  assign rst_cyc = (rst_dly_i == '0) ? CW'(US_CYC) : CW'(rst_dly_i) * CW'(US_CYC);
  assign tgt     = ~up_q;
  assign ack_ok  = (halted_i[pidx_q] == tgt);

  always_comb begin
    step_ld  = 1'b0;
    step_val = rst_cyc - 1'b1;
    unique case (state_q)
      S_RST_ON:   step_ld = (ridx_q == '0);
      S_RST_WAIT: if (step_zero && up_q) begin
                    step_ld  = 1'b1;
                    step_val = CW'(US_CYC - 1);
                  end
      S_CORE_ON:  step_ld = 1'b1;
      S_CORE_W1:  step_ld = step_zero;
      default:    step_ld = 1'b0;
    endcase
  end

  assign tmo_ld = (state_q == S_PREQ);

  pd_dly #(.W(CW)) u_step (
    .clk_i, .rst_ni, .load_i(step_ld), .val_i(step_val), .zero_o(step_zero)
  );

  pd_dly #(.W(CW)) u_tmo (
    .clk_i, .rst_ni, .load_i(tmo_ld), .val_i(CW'(TMO - 1)), .zero_o(tmo_zero)
  );

  pd_enall #(.DW(DLY_W)) u_enall (
    .clk_i, .rst_ni, .rail_i(rail_q), .dly_i(dly_q), .en_o(en_all_o)
  );

  // Control register fields owned by software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q     <= DLY_W'(DLY_INIT);
      cfg_ret_q <= 1'b0;
    end else if (cfg_we_i) begin
      dly_q     <= cfg_wdata_i[DLY_W-1:0];
      cfg_ret_q <= cfg_wdata_i[RET_B];
    end
  end

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[DLY_W-1:0] = dly_q;
    ctrl_o[CLAMP_B] = clamp_q;
    ctrl_o[RAIL_B]  = rail_q;
    ctrl_o[RET_B]   = cfg_ret_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      up_q       <= 1'b0;
      pidx_q     <= 1'b0;
      ridx_q     <= '0;
      halt_q     <= 2'b11;
      halt_sv_q  <= 2'b11;
      rail_q     <= 1'b0;
      clamp_q    <= 1'b1;
      rst_q      <= '1;
      ret_flag_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cmd_up_i) begin
            if (rail_q && !clamp_q) done_q <= 1'b1;
            else begin
              up_q <= 1'b1; pidx_q <= 1'b0; halt_sv_q <= halt_q; state_q <= S_PREQ;
            end
          end else if (cmd_down_i) begin
            if (!rail_q) done_q <= 1'b1;
            else begin
              up_q <= 1'b0; pidx_q <= 1'b0; halt_sv_q <= halt_q;
              ret_flag_q <= 1'b0; state_q <= S_PREQ;
            end
          end
        end
        S_PREQ: begin
          if (port_mask_i[pidx_q]) begin
            halt_q[pidx_q] <= tgt;
            state_q        <= S_PWAIT;
          end else if (!pidx_q) begin
            pidx_q <= 1'b1;
          end else begin
            ridx_q  <= LAST_IDX;
            state_q <= S_RST_ON;
          end
        end
        S_PWAIT: begin
          if (ack_ok) begin
            if (!pidx_q) begin
              pidx_q  <= 1'b1;
              state_q <= S_PREQ;
            end else begin
              ridx_q  <= LAST_IDX;
              state_q <= S_RST_ON;
            end
          end else if (tmo_zero) begin
            halt_q  <= halt_sv_q;
            if (!up_q) ret_flag_q <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_RST_ON: begin
          rst_q[ridx_q] <= 1'b1;
          if (ridx_q == '0) state_q <= S_RST_WAIT;
          else              ridx_q  <= ridx_q - 1'b1;
        end
        S_RST_WAIT: begin
          if (step_zero) begin
            if (up_q) begin
              rail_q  <= 1'b1;
              state_q <= S_US_WAIT;
            end else begin
              clamp_q <= 1'b1;
              state_q <= S_RAIL_OFF;
            end
          end
        end
        S_US_WAIT: begin
          if (step_zero) begin
            clamp_q <= 1'b0;
            ridx_q  <= '0;
            state_q <= S_RST_OFF;
          end
        end
        S_RST_OFF: begin
          rst_q[ridx_q] <= 1'b0;
          if (ridx_q == LAST_IDX) begin
            if (CORE_PULSE != 0) state_q <= S_CORE_ON;
            else begin
              ret_flag_q <= 1'b1; done_q <= 1'b1; state_q <= S_IDLE;
            end
          end else ridx_q <= ridx_q + 1'b1;
        end
        S_CORE_ON: begin
          rst_q[CORE_IDX] <= 1'b1;
          state_q         <= S_CORE_W1;
        end
        S_CORE_W1: begin
          if (step_zero) begin
            rst_q[CORE_IDX] <= 1'b0;
            state_q         <= S_CORE_W2;
          end
        end
        S_CORE_W2: begin
          if (step_zero) begin
            ret_flag_q <= 1'b1; done_q <= 1'b1; state_q <= S_IDLE;
          end
        end
        S_RAIL_OFF: begin
          rail_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign halt_o    = halt_q;
  assign rail_en_o = rail_q;
  assign clamp_o   = clamp_q;
  assign dom_rst_o = rst_q;
  assign retain_o  = ret_flag_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R5
  rail_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rail_en_o) |-> &dom_rst_o);
  // R5
  clamp_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clamp_o |-> rail_en_o);
  // R6
  rail_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rail_en_o) |-> clamp_o);
  // R10
  done_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));
  // R12
  idle_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_up_i && !cmd_down_i) |=> !busy_o);
  // R9
  halt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(halt_o));
  // R11
  enall_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_all_o |-> rail_en_o);
endmodule

// File: tb/pd_seq_tb_top.sv
module pd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRST = 4;
  localparam int US = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_up = 0, cmd_down = 0, cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0] rst_dly = '0;
  logic [1:0] mask = 2'b11, halted = 2'b11, stuck = 2'b00;
  logic [1:0] halt;
  logic rail, clamp, retain, en_all, busy, done, err;
  logic [NRST-1:0] drst;
  logic [15:0] ctrl;

  int checks = 0, failures = 0, cyc = 0, lat = 2;
  int t_rail_up, t_clamp_dn, t_clamp_up, t_en_up, t_cmd, t_done;
  int t_halt[2];
  int fall_first[NRST], rise_last[NRST], fall_cnt[NRST];
  int done_cnt, err_cnt, rail_chg;
  int wcnt[2];
  logic [1:0] p_halt; logic p_rail, p_clamp, p_en; logic [NRST-1:0] p_rst;
  logic m_rail, m_ret; logic [1:0] m_halt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_up_i(cmd_up), .cmd_down_i(cmd_down),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .rst_dly_i(rst_dly),
    .port_mask_i(mask), .halted_i(halted), .halt_o(halt), .rail_en_o(rail),
    .clamp_o(clamp), .dom_rst_o(drst), .retain_o(retain), .en_all_o(en_all),
    .ctrl_o(ctrl), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // Port responders
  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (halted[p] != halt[p] && !stuck[p]) begin
        if (wcnt[p] >= lat) begin halted[p] <= halt[p]; wcnt[p] = 0; end
        else wcnt[p] = wcnt[p] + 1;
      end else wcnt[p] = 0;
    end
  end

  // Event monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_ni) begin
      if (rail && !p_rail) t_rail_up = cyc;
      if (rail != p_rail) rail_chg = rail_chg + 1;
      if (!clamp && p_clamp) t_clamp_dn = cyc;
      if (clamp && !p_clamp) t_clamp_up = cyc;
      if (en_all && !p_en) t_en_up = cyc;
      for (int p = 0; p < 2; p++)
        if (halt[p] != p_halt[p] && t_halt[p] < 0) t_halt[p] = cyc;
      for (int i = 0; i < NRST; i++) begin
        if (!drst[i] && p_rst[i]) begin
          fall_cnt[i] = fall_cnt[i] + 1;
          if (fall_first[i] < 0) fall_first[i] = cyc;
        end
        if (drst[i] && !p_rst[i]) rise_last[i] = cyc;
      end
      if (done) begin done_cnt = done_cnt + 1; t_done = cyc; end
      if (err) err_cnt = err_cnt + 1;
    end
    p_rail = rail; p_clamp = clamp; p_en = en_all; p_halt = halt; p_rst = drst;
  end

  task automatic mon_clr();
    t_rail_up = -1; t_clamp_dn = -1; t_clamp_up = -1; t_en_up = -1; t_done = -1;
    t_halt[0] = -1; t_halt[1] = -1; done_cnt = 0; err_cnt = 0; rail_chg = 0;
    for (int i = 0; i < NRST; i++) begin
      fall_first[i] = -1; rise_last[i] = -1; fall_cnt[i] = 0;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic up, input logic dn, input int mid_dn);
    mon_clr();
    @(negedge clk);
    cmd_up = up; cmd_down = dn; t_cmd = cyc;
    @(negedge clk);
    cmd_up = 0; cmd_down = 0;
    for (int k = 0; k < 3000; k++) begin
      if (mid_dn > 0 && k == mid_dn) cmd_down = 1;
      if (mid_dn > 0 && k == mid_dn + 1) cmd_down = 0;
      if (done_cnt + err_cnt > 0 && !busy && k > mid_dn + 1) break;
      @(negedge clk);
    end
    repeat (12) @(negedge clk);
  endtask

  function automatic logic [1:0] exp_halt(input logic [1:0] cur, input logic [1:0] m,
                                          input logic up);
    logic [1:0] r = cur;
    for (int p = 0; p < 2; p++) if (m[p]) r[p] = ~up;
    return r;
  endfunction

  function automatic logic exp_fail(input logic [1:0] cur, input logic [1:0] m,
                                    input logic [1:0] st, input logic up);
    logic f = 1'b0;
    for (int p = 0; p < 2; p++) if (m[p] && st[p] && cur[p] != ~up) f = 1'b1;
    return f;
  endfunction

  task automatic chk_state(input string req, input logic on, input logic [1:0] eh,
                           input logic er);
    chk({req, " rail"}, rail, on);
    chk({req, " clamp"}, clamp, !on);
    chk({req, " rst"}, drst, on ? 0 : 4'hF);
    chk({req, " halt"}, halt, eh);
    chk({req, " retain"}, retain, er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mon_clr();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1", 0, 2'b11, 0);
    chk("R1 busy", busy, 0);
    chk("R1 en_all", en_all, 0);
    // R2 register layout
    chk("R2 ctrl reset", ctrl, 16'h003F);
    cfg_wdata = 16'h0303; cfg_we = 1; @(negedge clk); cfg_we = 0; @(negedge clk);
    chk("R2 ctrl write ignores rail bit", ctrl, 16'h0223);
    chk("R2 rail untouched", rail, 0);
    cfg_wdata = 16'h0003; cfg_we = 1; @(negedge clk); cfg_we = 0; @(negedge clk);
    chk("R2 ctrl ret clear", ctrl, 16'h0023);

    // R5 full power-up, reset delay default
    rst_dly = 0;
    run_cmd(1, 0, 0);
    chk_state("R5", 1, 2'b00, 1);
    chk("R5 done", done_cnt, 1);
    chk("R5 rail to unclamp", t_clamp_dn - t_rail_up, US);
    chk("R5 port order", t_halt[0] < t_halt[1], 1);
    chk("R5 unclamp before release", fall_first[0] > t_clamp_dn, 1);
    for (int i = 1; i < NRST; i++)
      chk("R5 forward release", fall_first[i] - fall_first[i-1], 1);
    chk("R8 core falls twice", fall_cnt[0], 2);
    chk("R8 other falls once", fall_cnt[1], 1);
    chk("R11 en_all delay", t_en_up - t_rail_up, 3);
    chk("R2 ctrl on", ctrl, 16'h0103);

    // R3 early exit
    run_cmd(1, 0, 0);
    chk("R3 done", done_cnt, 1);
    chk("R3 latency", (t_done - t_cmd) <= 2, 1);
    chk("R3 no change", rail_chg, 0);
    chk_state("R3", 1, 2'b00, 1);

    // R6 / R7 power-down with rst_dly=2
    rst_dly = 2;
    run_cmd(0, 1, 0);
    chk_state("R6", 0, 2'b11, 0);
    chk("R6 done", done_cnt, 1);
    chk("R6 port order", t_halt[0] < t_halt[1], 1);
    for (int i = 0; i < NRST - 1; i++)
      chk("R6 reverse assert", rise_last[i] - rise_last[i+1], 1);
    chk("R7 delay 2us", t_clamp_up - rise_last[0], 2 * US);
    chk("R6 rail off after clamp", t_clamp_up < 0 ? 0 : (dut_i.rail_en_o == 0), 1);
    chk("R11 en_all low", en_all, 0);

    // R4 early exit
    run_cmd(0, 1, 0);
    chk("R4 done", done_cnt, 1);
    chk("R4 latency", (t_done - t_cmd) <= 2, 1);
    chk("R4 no change", rail_chg, 0);

    // R12 down command while busy ignored
    rst_dly = 0;
    run_cmd(1, 0, 5);
    chk_state("R12 busy ignore", 1, 2'b00, 1);
    chk("R12 one done", done_cnt, 1);

    // R7 zero selects default
    run_cmd(0, 1, 0);
    chk("R7 default delay", t_clamp_up - rise_last[0], US);

    // R12 both commands: up wins
    run_cmd(1, 1, 0);
    chk_state("R12 up priority", 1, 2'b00, 1);

    // R10 abort during power-down
    stuck = 2'b10;
    run_cmd(0, 1, 0);
    chk("R10 err", err_cnt, 1);
    chk("R10 no done", done_cnt, 0);
    chk_state("R10 down abort", 1, 2'b00, 1);
    stuck = 0; repeat (10) @(negedge clk);
    run_cmd(0, 1, 0);
    chk_state("R6 after abort", 0, 2'b11, 0);

    // R10 abort during power-up
    stuck = 2'b10;
    run_cmd(1, 0, 0);
    chk("R10 up err", err_cnt, 1);
    chk_state("R10 up abort", 0, 2'b11, 0);
    stuck = 0; repeat (10) @(negedge clk);

    // R9 absent port skipped even when stuck
    mask = 2'b01; stuck = 2'b10;
    run_cmd(1, 0, 0);
    chk("R9 no err", err_cnt, 0);
    chk_state("R9 absent", 1, 2'b10, 1);
    stuck = 0; mask = 2'b11; repeat (10) @(negedge clk);
    run_cmd(0, 1, 0);
    chk_state("R9 restore", 0, 2'b11, 0);

    // Random phase with model
    m_rail = 0; m_ret = 0; m_halt = 2'b11;
    for (int it = 0; it < 24; it++) begin
      logic up, f;
      logic [1:0] st;
      up = $urandom % 2;
      mask = $urandom % 4;
      lat = $urandom % 6;
      rst_dly = $urandom % 3;
      st = (($urandom % 4) == 0) ? (2'b01 << ($urandom % 2)) : 2'b00;
      stuck = st;
      f = exp_fail(m_halt, mask, st, up);
      run_cmd(up, !up, 0);
      if (up ? m_rail : !m_rail) begin
        chk("R3 R4 random early", done_cnt, 1);
      end else if (f) begin
        chk("R10 random err", err_cnt, 1);
        if (!up) m_ret = 1;
      end else begin
        chk("R5 R6 random done", done_cnt, 1);
        m_rail = up; m_ret = up; m_halt = exp_halt(m_halt, mask, up);
      end
      chk_state("R9 random", m_rail, m_halt, m_ret);
      stuck = 0;
      repeat (10) @(negedge clk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule